// File: doc/BRIEF.md
# Banked Register File with Pair Access

This block holds the working registers of a small 8-bit processor: four banks of eight byte registers. A 2-bit bank pointer picks the bank that register-named accesses use. Inside that bank, software reaches a register as a single byte by its index, or as one of four 16-bit pairs built from two neighbouring registers. A pair exchange swaps the first pair with any of the other three.

The same storage also appears as a 32-byte window in a 16-bit data address space. A memory-side byte port reads and writes any bank through this window, whatever the bank pointer says. Reads on both sides are combinational. Writes take effect at the clock edge. When both sides write the same byte in one cycle, the memory side wins.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register in every bank reads 0x00 and the bank pointer `bank_cur` is 0.
- R2: A pulse on `bank_load` loads `bank_val` into `bank_cur` at the clock edge. Reads, writes and exchanges issued in that same cycle still use the old bank.
- R3: Byte index i selects register i of the active bank, in the order X=0, A=1, C=2, B=3, E=4, D=5, L=6, H=7. A byte write is visible on the byte read port in the next cycle.
- R4: Pair k (0=AX, 1=BC, 2=DE, 3=HL) reads as {register 2k+1 in bits 15:8, register 2k in bits 7:0}. A pair write updates both bytes in one edge.
- R5: The window covers 0xFEE0 to 0xFEFF. Bank b starts at 0xFEE0 + 8*(3-b), so bank 0 is at the top. Register i of that bank is at offset i. Inside the window `mem_hit` is 1 and `mem_rdata` returns the byte in the same cycle.
- R6: Outside the window `mem_hit` is 0 and `mem_rdata` is 0x00. A write there changes no register.
- R7: An exchange with partner k in 1..3 swaps pair 0 and pair k of the active bank. An exchange with k=0 changes nothing.
- R8: When CPU-side operations overlap on a byte in one cycle, the exchange takes precedence over the pair write, and the pair write takes precedence over the byte write.
- R9: A memory write to a register byte beats any CPU-side write to that same byte in that cycle. CPU-side writes to other bytes in that cycle still take effect.
- R10: CPU-side writes and exchanges touch only the active bank. The other banks keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_load | input | 1 | Load the bank pointer |
| bank_val | input | 2 | New bank pointer value |
| bank_cur | output | 2 | Active bank |
| rb_idx | input | 3 | Byte read index |
| rb_data | output | 8 | Byte read data |
| wb_en | input | 1 | Byte write enable |
| wb_idx | input | 3 | Byte write index |
| wb_data | input | 8 | Byte write data |
| rp_idx | input | 2 | Pair read index |
| rp_data | output | 16 | Pair read data |
| wp_en | input | 1 | Pair write enable |
| wp_idx | input | 2 | Pair write index |
| wp_data | input | 16 | Pair write data |
| xch_en | input | 1 | Exchange request |
| xch_idx | input | 2 | Exchange partner pair |
| mem_addr | input | 16 | Memory-side byte address |
| mem_we | input | 1 | Memory-side write enable |
| mem_wdata | input | 8 | Memory-side write data |
| mem_rdata | output | 8 | Memory-side read data |
| mem_hit | output | 1 | Address falls in the window |

## Verification
The readback properties assume that no other write reaches the same byte in the same cycle. The byte-port property only fires when no memory write, pair write, exchange or bank load is also active. The memory readback property only fires when the address is held for one more cycle. The bench drives each operation alone, and builds the overlapping cases on purpose, so the checks that cover them come from the bench's own model rather than from the assertions. Every input changes on the falling edge, and every read select is settled before the sample.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  localparam int unsigned DEF_DW    = 8;
  localparam int unsigned DEF_NR    = 8;
  localparam int unsigned DEF_NB    = 4;
  localparam int unsigned DEF_AW    = 16;
  localparam logic [15:0] DEF_BASE  = 16'hFEE0;

  // Byte positions inside a bank; a pair's low byte sits at the even slot.
  typedef enum logic [2:0] {
    REG_X = 3'd0, REG_A = 3'd1, REG_C = 3'd2, REG_B = 3'd3,
    REG_E = 3'd4, REG_D = 3'd5, REG_L = 3'd6, REG_H = 3'd7
  } reg_id_e;

  // Slot of the low (hi=0) or high (hi=1) byte of pair pidx.
  function automatic int unsigned pair_slot(int unsigned pidx, bit hi);
    return 2 * pidx + int'(hi);
  endfunction

  // Bank held in window block blk: bank 0 lives in the highest block.
  function automatic int unsigned bank_of_block(int unsigned blk, int unsigned nb);
    return nb - 1 - blk;
  endfunction
endpackage

// File: rtl/rf_win_decode.sv
`timescale 1ns/1ps
module rf_win_decode #(
  parameter int unsigned AW   = 16,
  parameter int unsigned NB   = 4,
  parameter int unsigned NR   = 8,
  parameter logic [AW-1:0] BASE = 16'hFEE0,
  localparam int unsigned IW  = $clog2(NR),
  localparam int unsigned BW  = $clog2(NB),
  localparam int unsigned SPAN = NB * NR
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [BW-1:0] bank,
  output logic [IW-1:0] idx
);
  logic [AW-1:0] off;
  logic [BW-1:0] blk;

  always_comb begin
    off  = addr - BASE;
    hit  = (addr >= BASE) && (off < AW'(SPAN));
    blk  = off[IW +: BW];
    bank = BW'(rf_pkg::bank_of_block(int'(blk), NB));
    idx  = off[IW-1:0];
  end
endmodule

// File: rtl/rf_cpu_port.sv
`timescale 1ns/1ps
module rf_cpu_port #(
  parameter int unsigned DW = 8,
  parameter int unsigned NR = 8,
  localparam int unsigned IW = $clog2(NR),
  localparam int unsigned PW = IW - 1
) (
  input  logic [NR-1:0][DW-1:0] bytes_i,
  input  logic [IW-1:0]         r_idx,
  output logic [DW-1:0]         r_d,
  input  logic [PW-1:0]         pr_idx,
  output logic [2*DW-1:0]       pr_d,
  input  logic                  b_we,
  input  logic [IW-1:0]         b_idx,
  input  logic [DW-1:0]         b_d,
  input  logic                  p_we,
  input  logic [PW-1:0]         p_idx,
  input  logic [2*DW-1:0]       p_d,
  input  logic                  x_en,
  input  logic [PW-1:0]         x_idx,
  output logic                  x_fire,
  output logic [NR-1:0]         we_o,
  output logic [NR-1:0][DW-1:0] d_o
);
  import rf_pkg::*;

  assign x_fire = x_en && (x_idx != '0);
  assign r_d    = bytes_i[r_idx];
  assign pr_d   = {bytes_i[pair_slot(int'(pr_idx), 1'b1)],
                   bytes_i[pair_slot(int'(pr_idx), 1'b0)]};

  // Later stages override earlier: byte < pair < exchange.
  always_comb begin
    we_o = '0;
    d_o  = bytes_i;
    if (b_we) begin
      we_o[b_idx] = 1'b1;
      d_o[b_idx]  = b_d;
    end
    if (p_we) begin
      we_o[pair_slot(int'(p_idx), 1'b0)] = 1'b1;
      we_o[pair_slot(int'(p_idx), 1'b1)] = 1'b1;
      d_o[pair_slot(int'(p_idx), 1'b0)]  = p_d[DW-1:0];
      d_o[pair_slot(int'(p_idx), 1'b1)]  = p_d[2*DW-1:DW];
    end
    if (x_fire) begin
      we_o[REG_X] = 1'b1;
      we_o[REG_A] = 1'b1;
      we_o[pair_slot(int'(x_idx), 1'b0)] = 1'b1;
      we_o[pair_slot(int'(x_idx), 1'b1)] = 1'b1;
      d_o[REG_X] = bytes_i[pair_slot(int'(x_idx), 1'b0)];
      d_o[REG_A] = bytes_i[pair_slot(int'(x_idx), 1'b1)];
      d_o[pair_slot(int'(x_idx), 1'b0)] = bytes_i[REG_X];
      d_o[pair_slot(int'(x_idx), 1'b1)] = bytes_i[REG_A];
    end
  end
endmodule

// File: rtl/rf_cell.sv
`timescale 1ns/1ps
module rf_cell #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_we,
  input  logic [DW-1:0] mem_d,
  input  logic          cpu_we,
  input  logic [DW-1:0] cpu_d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (mem_we) q <= mem_d;
    else if (cpu_we) q <= cpu_d;
  end
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile #(
  parameter int unsigned DW = rf_pkg::DEF_DW,
  parameter int unsigned NR = rf_pkg::DEF_NR,
  parameter int unsigned NB = rf_pkg::DEF_NB,
  parameter int unsigned AW = rf_pkg::DEF_AW,
  parameter logic [AW-1:0] WIN_BASE = rf_pkg::DEF_BASE,
  localparam int unsigned IW = $clog2(NR),
  localparam int unsigned BW = $clog2(NB),
  localparam int unsigned PW = IW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bank_load,
  input  logic [BW-1:0] bank_val,
  output logic [BW-1:0] bank_cur,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  logic [DW-1:0] wb_data,
  input  logic [PW-1:0] rp_idx,
  output logic [2*DW-1:0] rp_data,
  input  logic          wp_en,
  input  logic [PW-1:0] wp_idx,
  input  logic [2*DW-1:0] wp_data,
  input  logic          xch_en,
  input  logic [PW-1:0] xch_idx,
  input  logic [AW-1:0] mem_addr,
  input  logic          mem_we,
  input  logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] mem_rdata,
  output logic          mem_hit
);
  logic [DW-1:0]         regs_q [NB][NR];
  logic [NR-1:0][DW-1:0] act_bytes;
  logic [NR-1:0]         cpu_we;
  logic [NR-1:0][DW-1:0] cpu_d;
  logic [BW-1:0]         dec_bank;
  logic [IW-1:0]         dec_idx;
  // Named events for the checker.
  logic                  xch_fire;
  logic                  mem_wr_hit;
  logic [NB*NR-1:0]      mem_we_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bank_cur <= '0;
    else if (bank_load) bank_cur <= bank_val;
  end

  always_comb begin
    for (int i = 0; i < NR; i++) act_bytes[i] = regs_q[bank_cur][i];
  end

  rf_win_decode #(.AW(AW), .NB(NB), .NR(NR), .BASE(WIN_BASE)) u_dec (
    .addr (mem_addr),
    .hit  (mem_hit),
    .bank (dec_bank),
    .idx  (dec_idx)
  );

  assign mem_wr_hit = mem_we && mem_hit;
  assign mem_rdata  = mem_hit ? regs_q[dec_bank][dec_idx] : '0;

  rf_cpu_port #(.DW(DW), .NR(NR)) u_cpu (
    .bytes_i (act_bytes),
    .r_idx   (rb_idx),
    .r_d     (rb_data),
    .pr_idx  (rp_idx),
    .pr_d    (rp_data),
    .b_we    (wb_en),
    .b_idx   (wb_idx),
    .b_d     (wb_data),
    .p_we    (wp_en),
    .p_idx   (wp_idx),
    .p_d     (wp_data),
    .x_en    (xch_en),
    .x_idx   (xch_idx),
    .x_fire  (xch_fire),
    .we_o    (cpu_we),
    .d_o     (cpu_d)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    for (genvar i = 0; i < NR; i++) begin : g_reg
      logic sel_cpu;
      logic sel_mem;
      assign sel_cpu = cpu_we[i] && (bank_cur == BW'(b));
      assign sel_mem = mem_wr_hit && (dec_bank == BW'(b)) && (dec_idx == IW'(i));
      assign mem_we_vec[b*NR+i] = sel_mem;
      rf_cell #(.DW(DW)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .mem_we (sel_mem),
        .mem_d  (mem_wdata),
        .cpu_we (sel_cpu),
        .cpu_d  (cpu_d[i]),
        .q      (regs_q[b][i])
      );
    end
  end
endmodule

// File: rtl/rf_checker.sv
`timescale 1ns/1ps
module rf_checker #(
  parameter int unsigned DW = 8,
  parameter int unsigned NR = 8,
  parameter int unsigned NB = 4,
  parameter int unsigned AW = 16,
  localparam int unsigned IW = $clog2(NR),
  localparam int unsigned BW = $clog2(NB),
  localparam int unsigned PW = IW - 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bank_load,
  input logic [BW-1:0]         bank_val,
  input logic [BW-1:0]         bank_cur,
  input logic [IW-1:0]         rb_idx,
  input logic [DW-1:0]         rb_data,
  input logic                  wb_en,
  input logic [IW-1:0]         wb_idx,
  input logic [DW-1:0]         wb_data,
  input logic                  wp_en,
  input logic [PW-1:0]         xch_idx,
  input logic                  xch_fire,
  input logic [NR-1:0][DW-1:0] act_bytes,
  input logic [AW-1:0]         mem_addr,
  input logic [DW-1:0]         mem_wdata,
  input logic [DW-1:0]         mem_rdata,
  input logic                  mem_hit,
  input logic                  mem_wr_hit,
  input logic [NB*NR-1:0]      mem_we_vec
);
  logic [2*DW-1:0] act_ax;
  logic [2*DW-1:0] act_partner;
  assign act_ax      = {act_bytes[1], act_bytes[0]};
  assign act_partner = {act_bytes[{xch_idx, 1'b1}], act_bytes[{xch_idx, 1'b0}]};

  p_bank_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load |=> (bank_cur == $past(bank_val)));

  p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_load |=> $stable(bank_cur));

  p_byte_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !mem_wr_hit && !wp_en && !xch_fire && !bank_load) ##1 (rb_idx == $past(wb_idx))
    |-> (rb_data == $past(wb_data)));

  p_win_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_hit |-> (mem_rdata == '0));

  // R5 and R9: a memory write always lands, whatever the CPU side does.
  p_mem_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_hit ##1 (mem_addr == $past(mem_addr)) |-> (mem_rdata == $past(mem_wdata)));

  p_xchg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xch_fire && !mem_wr_hit && !bank_load) |=> (act_ax == $past(act_partner)));

  p_dec_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_we_vec));
endmodule

bind banked_regfile rf_checker #(.DW(DW), .NR(NR), .NB(NB), .AW(AW)) u_chk (.*);

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, bank_load, wb_en, wp_en, xch_en, mem_we, mem_hit;
  logic [1:0] bank_val, bank_cur, rp_idx, wp_idx, xch_idx;
  logic [2:0] rb_idx, wb_idx;
  logic [7:0] rb_data, wb_data, mem_wdata, mem_rdata;
  logic [15:0] rp_data, wp_data, mem_addr;

  banked_regfile dut_i (.*);

  logic [7:0] model [0:3][0:7];
  int mbank = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { int kind; logic [15:0] val; string tag; } item_t;
  item_t exp_q[$];
  event sample_ev;

  function automatic logic [15:0] win_addr(int b, int i);
    return 16'hFEE0 + 16'((3 - b) * 8 + i);
  endfunction

  // Monitor: pops the expected item and compares with the live outputs.
  initial forever begin
    @(sample_ev);
    while (exp_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        0: act = {8'h00, rb_data};
        1: act = rp_data;
        2: act = {7'h00, mem_hit, mem_rdata};
        default: act = {14'h0, bank_cur};
      endcase
      checks++;
      if (act !== it.val) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.val);
      end
    end
  end

  task automatic push(int kind, logic [15:0] v, string tag);
    item_t it;
    it.kind = kind; it.val = v; it.tag = tag;
    #0.5;
    exp_q.push_back(it);
    ->sample_ev;
    #0.1;
  endtask

  task automatic idle();
    bank_load = 0; wb_en = 0; wp_en = 0; xch_en = 0; mem_we = 0;
  endtask

  task automatic edge_done();
    @(posedge clk); #1; idle();
  endtask

  task automatic t_bank(int v);
    @(negedge clk); bank_load = 1; bank_val = 2'(v);
    edge_done(); mbank = v;
  endtask

  task automatic t_wbyte(int i, logic [7:0] d);
    @(negedge clk); wb_en = 1; wb_idx = 3'(i); wb_data = d;
    edge_done(); model[mbank][i] = d;
  endtask

  task automatic t_wpair(int k, logic [15:0] d);
    @(negedge clk); wp_en = 1; wp_idx = 2'(k); wp_data = d;
    edge_done(); model[mbank][2*k] = d[7:0]; model[mbank][2*k+1] = d[15:8];
  endtask

  task automatic t_mwr(logic [15:0] a, logic [7:0] d);
    int off;
    @(negedge clk); mem_we = 1; mem_addr = a; mem_wdata = d;
    edge_done();
    if (a >= 16'hFEE0 && a <= 16'hFEFF) begin
      off = int'(a - 16'hFEE0);
      model[3 - off / 8][off % 8] = d;
    end
  endtask

  task automatic swap_pairs(int k);
    logic [7:0] lo, hi;
    lo = model[mbank][0]; hi = model[mbank][1];
    model[mbank][0] = model[mbank][2*k]; model[mbank][1] = model[mbank][2*k+1];
    model[mbank][2*k] = lo; model[mbank][2*k+1] = hi;
  endtask

  task automatic t_xch(int k);
    @(negedge clk); xch_en = 1; xch_idx = 2'(k);
    edge_done();
    if (k != 0) swap_pairs(k);
  endtask

  task automatic c_byte(int i, string tag);
    @(negedge clk); rb_idx = 3'(i); push(0, {8'h00, model[mbank][i]}, tag);
  endtask

  task automatic c_pair(int k, string tag);
    @(negedge clk); rp_idx = 2'(k);
    push(1, {model[mbank][2*k+1], model[mbank][2*k]}, tag);
  endtask

  task automatic c_mem(int b, int i, string tag);
    @(negedge clk); mem_addr = win_addr(b, i); push(2, {7'h00, 1'b1, model[b][i]}, tag);
  endtask

  task automatic c_miss(logic [15:0] a, string tag);
    @(negedge clk); mem_addr = a; push(2, 16'h0000, tag);
  endtask

  task automatic c_bank(string tag);
    @(negedge clk); push(4, 16'(mbank), tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) for (int i = 0; i < 8; i++) model[b][i] = 8'h00;
    rst_n = 0; idle();
    bank_val = 0; rb_idx = 0; wb_idx = 0; wb_data = 0; rp_idx = 0; wp_idx = 0;
    wp_data = 0; xch_idx = 0; mem_addr = 0; mem_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state.
    c_bank("R1");
    for (int b = 0; b < 4; b++) for (int i = 0; i < 8; i++) c_mem(b, i, "R1");

    // Write through each view, read back through the others, per bank.
    for (int b = 0; b < 4; b++) begin
      t_bank(b); c_bank("R2");
      for (int i = 0; i < 8; i++) t_wbyte(i, 8'(b * 16 + i * 3 + 1));
      for (int i = 0; i < 8; i++) c_byte(i, "R3");
      for (int i = 0; i < 8; i++) c_mem(b, i, "R5");
      for (int k = 0; k < 4; k++) c_pair(k, "R4");
      for (int k = 0; k < 4; k++) t_wpair(k, 16'hA000 ^ 16'(b * 256 + k * 17));
      for (int k = 0; k < 4; k++) c_pair(k, "R4");
      for (int i = 0; i < 8; i++) c_mem(b, i, "R4");
      for (int i = 0; i < 8; i++) t_mwr(win_addr(b, i), 8'(8'hC0 + b * 8 + i));
      for (int i = 0; i < 8; i++) c_byte(i, "R5");
      for (int k = 0; k < 4; k++) c_pair(k, "R5");
    end
    // R10: CPU writes in one bank left the others intact.
    t_bank(1); t_wpair(2, 16'h7E7F); t_wbyte(7, 8'h99);
    for (int b = 0; b < 4; b++) for (int i = 0; i < 8; i++) c_mem(b, i, "R10");

    // R2: same-cycle bank load and byte write use the old bank.
    t_bank(3);
    @(negedge clk); bank_load = 1; bank_val = 2'd1; wb_en = 1; wb_idx = 3'd1; wb_data = 8'h5C;
    edge_done(); model[3][1] = 8'h5C; mbank = 1;
    c_bank("R2"); c_mem(3, 1, "R2"); c_mem(1, 1, "R2");

    // R5 edges and R6 misses.
    c_mem(3, 0, "R5"); c_mem(0, 7, "R5");
    t_mwr(16'hFEDF, 8'h77); t_mwr(16'hFF00, 8'h88); t_mwr(16'h0000, 8'h11);
    c_miss(16'hFEDF, "R6"); c_miss(16'hFF00, "R6");
    for (int b = 0; b < 4; b++) for (int i = 0; i < 8; i++) c_mem(b, i, "R6");

    // R7: exchanges in bank 2.
    t_bank(2);
    for (int k = 1; k < 4; k++) begin
      t_xch(k); c_pair(0, "R7"); c_pair(k, "R7");
    end
    t_xch(0);
    for (int k = 0; k < 4; k++) c_pair(k, "R7");
    c_mem(0, 0, "R7");

    // R8: pair write beats byte write on the same byte.
    @(negedge clk); wb_en = 1; wb_idx = 3'd3; wb_data = 8'h11; wp_en = 1; wp_idx = 2'd1; wp_data = 16'hBEEF;
    edge_done(); model[2][2] = 8'hEF; model[2][3] = 8'hBE;
    c_pair(1, "R8"); c_byte(3, "R8");
    // R8: exchange beats pair write.
    @(negedge clk); xch_en = 1; xch_idx = 2'd1; wp_en = 1; wp_idx = 2'd0; wp_data = 16'h5555;
    edge_done(); swap_pairs(1);
    c_pair(0, "R8"); c_pair(1, "R8");

    // R9: memory write beats byte write; other CPU bytes still land.
    @(negedge clk); mem_we = 1; mem_addr = win_addr(2, 5); mem_wdata = 8'hC3;
    wb_en = 1; wb_idx = 3'd5; wb_data = 8'h3C; wp_en = 1; wp_idx = 2'd0; wp_data = 16'h0102;
    edge_done(); model[2][5] = 8'hC3; model[2][0] = 8'h02; model[2][1] = 8'h01;
    c_byte(5, "R9"); c_pair(0, "R9"); c_mem(2, 5, "R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule